// File: doc/BRIEF.md
# SPI FIFO Status and Timeout Unit

This block sits between the register interface of an SPI controller and its shift engine. It keeps two queues of 32-bit words, eight entries each: one that the host fills and the engine drains for transmission, and one that the engine fills with received words and the host drains. Each queue reports its occupancy and its empty and full states. From these counts the block derives two threshold status bits. The receive bit rises when the queue holds more words than the host threshold. The transmit bit rises when the queue holds no more words than its threshold.

The block also guards the receive path. A word that the engine delivers into a full receive queue is dropped and raises a sticky overrun flag. A receive timeout flag rises when received data sits unread for a fixed number of serial clock periods. Single-cycle host strobes clear either queue, and write-one strobes clear the overrun and timeout flags. One interrupt output combines the receive-threshold, transmit-threshold and overrun conditions, each through its own enable.

Top module: `spi_fifo_stat`

## Requirements
- R1: Each queue holds at most 8 words. Its 4-bit count goes from 0 to 8. The empty output is 1 exactly when the count is 0, and the full output is 1 exactly when the count is 8. Counts and flags change on the clock edge that accepts the push or pop.
- R2: Each queue returns words in the order they were written. The head word is shown combinationally on `tx_pdata` and `rx_rdata` while the queue is not empty.
- R3: `rx_lvl_sts` is 1 when the receive count is strictly greater than `rx_thresh` (range 0..7), and 0 otherwise.
- R4: `tx_lvl_sts` is 1 when the transmit count is less than or equal to `tx_thresh`, and 0 otherwise. With a count of 0 and a threshold of 0, it is 1.
- R5: An `rx_push` while the receive queue is full drops the word, leaves the count at 8 and sets `ovr_sts`. The flag stays set until a cycle with `ovr_w1c` high.
- R6: A `tx_wr` while the transmit queue is full is ignored. An `rx_rd` while the receive queue is empty returns zero on `rx_rdata` and changes neither the count nor the order of later words.
- R7: `rx_clr` or `tx_clr` sets that queue's count to 0 and its empty flag to 1 on the next edge. A clear wins over a push or pop in the same cycle.
- R8: When `tmo_en` is 1 and the receive queue stays non-empty and unread, `tmo_sts` sets on the edge that takes the 64th `sclk_tick` pulse. It never sets while `tmo_en` is 0 or while the queue is empty.
- R9: An `rx_rd` clears `tmo_sts` and restarts the tick count from zero. `tmo_w1c` also clears the flag.
- R10: `irq` is the OR of (`rx_lvl_sts` AND `rxint_en`), (`tx_lvl_sts` AND `txint_en`) and (`ovr_sts` AND `ovrint_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Host strobe: push `tx_wdata` into the transmit queue |
| tx_wdata | input | 32 | Host transmit word |
| tx_clr | input | 1 | Host strobe: empty the transmit queue |
| tx_thresh | input | 3 | Transmit threshold |
| rx_rd | input | 1 | Host strobe: pop the receive queue head |
| rx_rdata | output | 32 | Receive queue head, or zero when empty |
| rx_clr | input | 1 | Host strobe: empty the receive queue |
| rx_thresh | input | 3 | Receive threshold |
| rxint_en | input | 1 | Enables the receive threshold onto `irq` |
| txint_en | input | 1 | Enables the transmit threshold onto `irq` |
| ovrint_en | input | 1 | Enables overrun onto `irq` |
| tmo_en | input | 1 | Enables the receive timeout |
| ovr_w1c | input | 1 | Clears `ovr_sts` |
| tmo_w1c | input | 1 | Clears `tmo_sts` |
| tx_pop | input | 1 | Engine strobe: remove the transmit head |
| tx_pdata | output | 32 | Transmit queue head, or zero when empty |
| rx_push | input | 1 | Engine strobe: push `rx_pdata` into the receive queue |
| rx_pdata | input | 32 | Engine received word |
| sclk_tick | input | 1 | One pulse per serial clock period |
| tx_cnt | output | 4 | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_cnt | output | 4 | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_lvl_sts | output | 1 | Receive threshold status |
| tx_lvl_sts | output | 1 | Transmit threshold status |
| ovr_sts | output | 1 | Sticky receive overrun flag |
| tmo_sts | output | 1 | Receive timeout flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the timeout boundary after a partial drain. The flag must stay low after 63 ticks and rise on the 64th. A read that leaves data in the queue must restart the count, so the time measured before the read must not carry over. The stimulus holds `sclk_tick` high for an exact number of cycles. It fills two words, runs 40 ticks, reads one word, and then checks the flag after 63 and after 64 further ticks. Overrun is reached by filling the receive queue to eight and pushing once more. The stimulus then drains it and confirms that the dropped word never comes out.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned Q_DEPTH   = 8;
  parameter int unsigned THR_W     = 3;
  parameter int unsigned TMO_TICKS = 64;
  localparam int unsigned CNT_W    = $clog2(Q_DEPTH) + 1;
endpackage

// File: rtl/sff_queue.sv
module sff_queue #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign drop    = push && full && !clr;
  assign head    = empty ? '0 : mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_d = cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt    <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/sff_rxtmo.sv
module sff_rxtmo #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned TW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic q_empty,
  input  logic rd,
  input  logic q_clr,
  input  logic w1c,
  output logic flag
);
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          flag_d, hit;

  assign hit = en && !q_empty && !rd && !q_clr && tick && (tcnt_q == TW'(LIMIT - 1));

  always_comb begin
    tcnt_d = tcnt_q;
    if (!en || q_empty || rd || q_clr) tcnt_d = '0;
    else if (tick)                     tcnt_d = hit ? '0 : tcnt_q + 1'b1;
    flag_d = flag;
    if (rd || w1c) flag_d = 1'b0;
    if (hit)       flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      flag   <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      flag   <= flag_d;
    end
  end
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = Q_DEPTH,
  parameter int unsigned TW    = THR_W,
  parameter int unsigned TICKS = TMO_TICKS,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_clr,
  input  logic [TW-1:0] tx_thresh,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  input  logic          rx_clr,
  input  logic [TW-1:0] rx_thresh,
  input  logic          rxint_en,
  input  logic          txint_en,
  input  logic          ovrint_en,
  input  logic          tmo_en,
  input  logic          ovr_w1c,
  input  logic          tmo_w1c,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_pdata,
  input  logic          sclk_tick,
  output logic [CW-1:0] tx_cnt,
  output logic          tx_empty,
  output logic          tx_full,
  output logic [CW-1:0] rx_cnt,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_lvl_sts,
  output logic          tx_lvl_sts,
  output logic          ovr_sts,
  output logic          tmo_sts,
  output logic          irq
);
  logic tx_drop, rx_drop, ovr_d;

  sff_queue #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_wr), .wdata(tx_wdata),
    .pop(tx_pop), .head(tx_pdata), .cnt(tx_cnt), .full(tx_full),
    .empty(tx_empty), .drop(tx_drop)
  );

  sff_queue #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(rx_pdata),
    .pop(rx_rd), .head(rx_rdata), .cnt(rx_cnt), .full(rx_full),
    .empty(rx_empty), .drop(rx_drop)
  );

  sff_rxtmo #(.LIMIT(TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .en(tmo_en), .tick(sclk_tick), .q_empty(rx_empty),
    .rd(rx_rd), .q_clr(rx_clr), .w1c(tmo_w1c), .flag(tmo_sts)
  );

  assign rx_lvl_sts = (rx_cnt > CW'(rx_thresh));
  assign tx_lvl_sts = (tx_cnt <= CW'(tx_thresh));

  always_comb begin
    ovr_d = ovr_sts;
    if (ovr_w1c) ovr_d = 1'b0;
    if (rx_drop) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_sts <= 1'b0;
    else        ovr_sts <= ovr_d;
  end

  assign irq = (rx_lvl_sts && rxint_en) || (tx_lvl_sts && txint_en) ||
               (ovr_sts && ovrint_en);

  logic unused_ok;
  assign unused_ok = tx_drop;
endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_wr,
  input logic          tx_pop,
  input logic          tx_clr,
  input logic          rx_push,
  input logic          rx_rd,
  input logic          rx_clr,
  input logic          ovr_w1c,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_full,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          tx_empty,
  input logic          ovr_sts,
  input logic          tmo_sts
);
  localparam logic [CW-1:0] FULLV = CW'(1 << (CW - 1));

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= FULLV) && (tx_cnt <= FULLV));
  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_clr) |=> (ovr_sts && rx_cnt == FULLV));
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_sts && !ovr_w1c) |=> ovr_sts);
  a_r6_tx_full_ign: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !tx_pop && !tx_clr) |=> (tx_cnt == FULLV));
  a_r7_rx_clr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_empty && rx_cnt == '0));
  a_r7_tx_clr: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_empty && tx_cnt == '0));
  a_r9_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !tmo_sts);
  a_r8_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_sts) |-> !rx_empty);
endmodule

bind spi_fifo_stat spi_fifo_stat_chk #(.CW(CW)) u_chk (.*);

// File: tb/spi_fifo_stat_bench.sv
module spi_fifo_stat_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr = 0, tx_clr = 0, rx_rd = 0, rx_clr = 0, tx_pop = 0, rx_push = 0;
  logic rxint_en = 0, txint_en = 0, ovrint_en = 0, tmo_en = 0;
  logic ovr_w1c = 0, tmo_w1c = 0, sclk_tick = 0;
  logic [31:0] tx_wdata = 0, rx_pdata = 0;
  logic [2:0]  tx_thresh = 0, rx_thresh = 0;
  logic [31:0] rx_rdata, tx_pdata;
  logic [3:0]  tx_cnt, rx_cnt;
  logic tx_empty, tx_full, rx_empty, rx_full, rx_lvl_sts, tx_lvl_sts;
  logic ovr_sts, tmo_sts, irq;

  int checks = 0, errors = 0;
  logic [31:0] txq[$], rxq[$];
  int mtx = 0, mrx = 0;

  always #10 clk = ~clk;

  spi_fifo_stat u_spi_fifo_stat (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic stepc();
    @(negedge clk);
  endtask

  task automatic wr_tx(input logic [31:0] d);
    tx_wr = 1; tx_wdata = d;
    stepc();
    tx_wr = 0;
    if (mtx < 8) begin txq.push_back(d); mtx++; end
  endtask

  task automatic push_rx(input logic [31:0] d);
    rx_push = 1; rx_pdata = d;
    stepc();
    rx_push = 0;
    if (mrx < 8) begin rxq.push_back(d); mrx++; end
  endtask

  task automatic pop_tx();
    logic [31:0] e;
    e = txq.pop_front();
    chk(tx_pdata, e, "R2 tx order");
    tx_pop = 1; stepc(); tx_pop = 0; mtx--;
  endtask

  task automatic rd_rx();
    logic [31:0] e;
    e = rxq.pop_front();
    chk(rx_rdata, e, "R2 rx order");
    rx_rd = 1; stepc(); rx_rd = 0; mrx--;
  endtask

  task automatic ticks(input int n);
    sclk_tick = 1;
    repeat (n) stepc();
    sclk_tick = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) stepc();
    rst_n = 1;
    stepc();
    chk(rx_empty, 1, "R1 reset rx_empty");
    chk(tx_empty, 1, "R1 reset tx_empty");
    chk(rx_cnt, 0, "R1 reset rx_cnt");
    chk(tx_lvl_sts, 1, "R4 count0 thresh0");
    chk(irq, 0, "R10 reset irq");
    chk(tx_pdata, 0, "R2 empty tx head");

    tx_thresh = 3;
    for (int i = 0; i < 8; i++) begin
      wr_tx(32'hA000_0000 + i);
      chk(tx_cnt, mtx, "R1 tx count");
      chk(tx_lvl_sts, (mtx <= 3), "R4 tx level");
    end
    chk(tx_full, 1, "R1 tx full");
    wr_tx(32'hDEAD_BEEF);
    chk(tx_cnt, 8, "R6 tx full write ignored");
    txint_en = 1; stepc();
    chk(irq, 0, "R10 tx level off");
    while (mtx > 0) pop_tx();
    chk(tx_empty, 1, "R1 tx drained");
    chk(irq, 1, "R10 tx level gated on");
    txint_en = 0;

    rx_thresh = 2; rxint_en = 1;
    for (int i = 0; i < 8; i++) begin
      push_rx(32'h5500_0010 + i);
      chk(rx_lvl_sts, (mrx > 2), "R3 rx level");
      chk(irq, (mrx > 2), "R10 rx irq");
    end
    chk(rx_full, 1, "R1 rx full");
    chk(ovr_sts, 0, "R5 no overrun yet");
    push_rx(32'hBAD0_0000);
    chk(ovr_sts, 1, "R5 overrun set");
    chk(rx_cnt, 8, "R5 word dropped count");
    rxint_en = 0; ovrint_en = 1; stepc();
    chk(irq, 1, "R10 overrun irq");
    while (mrx > 0) rd_rx();
    chk(ovr_sts, 1, "R5 overrun sticky");
    chk(rx_rdata, 0, "R6 empty read data");
    rx_rd = 1; stepc(); rx_rd = 0;
    chk(rx_cnt, 0, "R6 empty read count");
    ovr_w1c = 1; stepc(); ovr_w1c = 0;
    chk(ovr_sts, 0, "R5 overrun cleared");
    chk(irq, 0, "R10 irq low");
    ovrint_en = 0;
    push_rx(32'h0000_0077);
    chk(rx_rdata, 32'h77, "R6 order after empty read");
    rd_rx();

    for (int i = 0; i < 3; i++) push_rx(32'hC0 + i);
    rx_clr = 1; rx_push = 1; rx_pdata = 32'hFF; stepc();
    rx_clr = 0; rx_push = 0; rxq.delete(); mrx = 0;
    chk(rx_cnt, 0, "R7 rx clear count");
    chk(rx_empty, 1, "R7 rx clear empty");
    for (int i = 0; i < 3; i++) wr_tx(32'hE0 + i);
    tx_clr = 1; stepc(); tx_clr = 0; txq.delete(); mtx = 0;
    chk(tx_cnt, 0, "R7 tx clear count");
    chk(tx_empty, 1, "R7 tx clear empty");

    tmo_en = 1;
    push_rx(32'h1111);
    ticks(63);
    chk(tmo_sts, 0, "R8 63 ticks");
    ticks(1);
    chk(tmo_sts, 1, "R8 64th tick");
    rd_rx();
    chk(tmo_sts, 0, "R9 read clears");

    push_rx(32'h2222); push_rx(32'h3333);
    ticks(40);
    rd_rx();
    ticks(63);
    chk(tmo_sts, 0, "R9 read restarts count");
    ticks(1);
    chk(tmo_sts, 1, "R8 timeout after restart");
    tmo_w1c = 1; stepc(); tmo_w1c = 0;
    chk(tmo_sts, 0, "R9 w1c clears");
    rd_rx();
    ticks(70);
    chk(tmo_sts, 0, "R8 empty holds off");

    tmo_en = 0;
    push_rx(32'h4444);
    ticks(70);
    chk(tmo_sts, 0, "R8 disabled");
    rd_rx();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule